// File: doc/BRIEF.md
# Shared Cache Tag Controller with Banked Data

This block is the tag and control front end of a line cache that four cores share. Each core presents line read requests on its own port. One lookup is accepted per cycle against a 16-way set-associative tag array. A hit reads one of four small data banks. The bank is enabled only once the tag compare has reported a hit, so a miss never spends bank energy. A miss raises a fill request that carries the line address. The line returns later on the fill port, which allocates a way and writes the bank.

The tag array includes every line the cores hold, and each entry records which cores have the line. This lets the array act as a filter for external coherence probes. A probe that misses is answered "not present" at once and reaches no core. A probe that hits is forwarded only to the cores whose presence bit is set. When a fill evicts a line that some cores still hold, those cores receive a back-invalidate, which keeps the array inclusive. Everything runs on the core clock.

Top module: `shared_tag_ctrl`

## Requirements
- R1: After reset every way is invalid, and no response, fill request, probe response or back-invalidate is valid.
- R2: At most one core grant per cycle. Among the requesting cores, the first one at or after a rotating pointer wins, and the pointer moves to the winner plus one, so four cores that keep requesting are granted in cyclic order.
- R3: A fill input takes the lookup slot over probes and cores, and deasserts probe_ready_o. A probe takes it over cores. Core grants are zero in either cycle. A probe response appears on the cycle after the probe is accepted.
- R4: The cycle after a grant that hits, rsp_valid_o=1, rsp_hit_o=1, rsp_core_o is the granted core, and rsp_data_o is the word last filled into that line.
- R5: The cycle after a grant that misses, rsp_hit_o=0 and rsp_data_o=0. fill_req_o pulses with the requested line address and core.
- R6: The line address is {tag, set} with the set in the low bits, and the bank is the two lowest set bits. A hit to a bank that was read or filled in the previous cycle is not granted that cycle and is granted in the next one. A miss is never stalled by a busy bank.
- R7: A probe that misses gives probe_hit_o=0 and probe_fwd_o=0.
- R8: A probe that hits gives probe_hit_o=1, and probe_fwd_o equals the line's presence mask (bit i = core i). A fill sets the mask to the filling core alone. A core hit adds that core's bit.
- R9: A fill takes the lowest invalid way of the set. If the set is full, it takes the way named by a binary tree of 15 bits. From the root, each node bit selects the left half (0) or the right half (1). Every access to a way sets the nodes on its path to point to the other half. The replaced line misses afterwards.
- R10: When a fill evicts a valid line with a nonzero presence mask, binv_valid_o pulses on the next cycle with the evicted line address and that mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| core_req_i | input | NUM_CORES | Per-core request valid |
| core_addr_i | input | NUM_CORES*LINE_W | Per-core line address, core i in slice i |
| core_gnt_o | output | NUM_CORES | Request accepted this cycle |
| rsp_valid_o | output | 1 | Lookup response valid |
| rsp_core_o | output | CORE_W | Core the response belongs to |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_data_o | output | DATA_W | Bank data on hit, zero on miss |
| fill_req_o | output | 1 | Miss needs a line fetched |
| fill_req_addr_o | output | LINE_W | Missing line address |
| fill_req_core_o | output | CORE_W | Core that missed |
| fill_valid_i | input | 1 | Returning line |
| fill_addr_i | input | LINE_W | Line address of the fill |
| fill_core_i | input | CORE_W | Core the line is for |
| fill_data_i | input | DATA_W | Line data word |
| probe_valid_i | input | 1 | External probe |
| probe_addr_i | input | LINE_W | Probed line address |
| probe_ready_o | output | 1 | Probe accepted this cycle |
| probe_rsp_valid_o | output | 1 | Probe answer valid |
| probe_hit_o | output | 1 | Line present in some core |
| probe_fwd_o | output | NUM_CORES | Cores the probe is forwarded to |
| binv_valid_o | output | 1 | Back-invalidate valid |
| binv_addr_o | output | LINE_W | Evicted line address |
| binv_mask_o | output | NUM_CORES | Cores to invalidate |

## Verification
The bench builds the block with 8 sets, 6-bit tags and 8-bit data, and keeps 16 ways, 4 cores and 4 banks. With that size the bench can fill all 16 ways of a set and hit each of them in turn. It can also probe every line, and check the exact victim sequence of the tree after a complete access order. Back-to-back hits on one bank show the one-cycle stall. Four simultaneous misses on another bank show the cyclic grant order.

// File: rtl/shared_cache_pkg.sv
package shared_cache_pkg;
  typedef enum logic [1:0] {SRC_NONE, SRC_FILL, SRC_PROBE, SRC_CORE} src_e;
endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int N  = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          adv_i,
  output logic [IW-1:0] win_o,
  output logic          any_o
);
  logic [IW-1:0] ptr_q;

  always_comb begin
    logic [IW-1:0] idx;
    win_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      idx = ptr_q + IW'(i);
      if (req_i[idx]) begin
        win_o = idx;
        any_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (adv_i) ptr_q <= win_o + 1'b1;
  end
endmodule

// File: rtl/plru_tree.sv
module plru_tree #(
  parameter int WAYS = 16,
  localparam int WW = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input  logic [NODES-1:0] tree_i,
  input  logic [WW-1:0]    acc_way_i,
  output logic [WW-1:0]    victim_o,
  output logic [NODES-1:0] tree_o
);
  always_comb begin
    int n;
    n = 1;
    for (int l = 0; l < WW; l++) n = 2 * n + int'(tree_i[n-1]);
    victim_o = WW'(n - WAYS);
  end

  // point every node on the accessed path to the sibling half
  always_comb begin
    int m;
    tree_o = tree_i;
    m = int'(acc_way_i) + WAYS;
    for (int l = 0; l < WW; l++) begin
      tree_o[(m >> 1) - 1] = ((m % 2) == 0);
      m = m >> 1;
    end
  end
endmodule

// File: rtl/data_bank.sv
module data_bank #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/shared_tag_ctrl.sv
module shared_tag_ctrl import shared_cache_pkg::*; #(
  parameter int NUM_CORES = 4,
  parameter int NUM_WAYS  = 16,
  parameter int NUM_BANKS = 4,
  parameter int SET_BITS  = 6,
  parameter int TAG_BITS  = 20,
  parameter int DATA_W    = 32,
  localparam int LINE_W   = TAG_BITS + SET_BITS,
  localparam int CORE_W   = $clog2(NUM_CORES)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_CORES-1:0]        core_req_i,
  input  logic [NUM_CORES*LINE_W-1:0] core_addr_i,
  output logic [NUM_CORES-1:0]        core_gnt_o,
  output logic                        rsp_valid_o,
  output logic [CORE_W-1:0]           rsp_core_o,
  output logic                        rsp_hit_o,
  output logic [DATA_W-1:0]           rsp_data_o,
  output logic                        fill_req_o,
  output logic [LINE_W-1:0]           fill_req_addr_o,
  output logic [CORE_W-1:0]           fill_req_core_o,
  input  logic                        fill_valid_i,
  input  logic [LINE_W-1:0]           fill_addr_i,
  input  logic [CORE_W-1:0]           fill_core_i,
  input  logic [DATA_W-1:0]           fill_data_i,
  input  logic                        probe_valid_i,
  input  logic [LINE_W-1:0]           probe_addr_i,
  output logic                        probe_ready_o,
  output logic                        probe_rsp_valid_o,
  output logic                        probe_hit_o,
  output logic [NUM_CORES-1:0]        probe_fwd_o,
  output logic                        binv_valid_o,
  output logic [LINE_W-1:0]           binv_addr_o,
  output logic [NUM_CORES-1:0]        binv_mask_o
);
  localparam int NUM_SETS   = 1 << SET_BITS;
  localparam int WAY_W      = $clog2(NUM_WAYS);
  localparam int BANK_W     = $clog2(NUM_BANKS);
  localparam int NODES      = NUM_WAYS - 1;
  localparam int BANK_DEPTH = (NUM_SETS / NUM_BANKS) * NUM_WAYS;

  logic [TAG_BITS-1:0]  tag_q  [NUM_SETS][NUM_WAYS];
  logic [NUM_CORES-1:0] pres_q [NUM_SETS][NUM_WAYS];
  logic [NUM_WAYS-1:0]  vld_q  [NUM_SETS];
  logic [NODES-1:0]     tree_q [NUM_SETS];
  logic [NUM_BANKS-1:0] busy_q;

  logic [CORE_W-1:0]   win;
  logic                arb_any, core_acc, stall, hit, any_inv, tree_upd;
  src_e                src;
  logic [LINE_W-1:0]   lk_addr;
  logic [SET_BITS-1:0] set;
  logic [TAG_BITS-1:0] tag;
  logic [BANK_W-1:0]   bank;
  logic [WAY_W-1:0]    hit_way, inv_way, plru_way, victim, way_sel;
  logic [NODES-1:0]    tree_nxt;
  logic [NUM_BANKS-1:0] bank_we, bank_re;
  logic [$clog2(BANK_DEPTH)-1:0] bank_idx;
  logic [DATA_W-1:0]   bank_rdata [NUM_BANKS];
  logic [BANK_W-1:0]   rsp_bank_q;

  rr_arbiter #(.N(NUM_CORES)) u_arb (
    .clk_i, .rst_ni, .req_i(core_req_i), .adv_i(core_acc), .win_o(win), .any_o(arb_any)
  );

  always_comb begin
    if (fill_valid_i) begin
      src = SRC_FILL;  lk_addr = fill_addr_i;
    end else if (probe_valid_i) begin
      src = SRC_PROBE; lk_addr = probe_addr_i;
    end else if (arb_any) begin
      src = SRC_CORE;  lk_addr = core_addr_i[win*LINE_W +: LINE_W];
    end else begin
      src = SRC_NONE;  lk_addr = '0;
    end
  end

  assign set  = lk_addr[SET_BITS-1:0];
  assign tag  = lk_addr[LINE_W-1:SET_BITS];
  assign bank = set[BANK_W-1:0];

  always_comb begin
    hit = 1'b0; hit_way = '0; any_inv = 1'b0; inv_way = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (vld_q[set][w] && tag_q[set][w] == tag) begin
        hit = 1'b1; hit_way = WAY_W'(w);
      end
      if (!vld_q[set][w]) begin
        any_inv = 1'b1; inv_way = WAY_W'(w);
      end
    end
  end

  plru_tree #(.WAYS(NUM_WAYS)) u_plru (
    .tree_i(tree_q[set]), .acc_way_i(way_sel), .victim_o(plru_way), .tree_o(tree_nxt)
  );

  assign victim   = any_inv ? inv_way : plru_way;
  assign way_sel  = (src == SRC_FILL) ? victim : hit_way;
  assign stall    = (src == SRC_CORE) && hit && busy_q[bank];
  assign core_acc = (src == SRC_CORE) && !stall;
  assign tree_upd = (src == SRC_FILL) || (core_acc && hit);
  assign core_gnt_o    = core_acc ? (NUM_CORES'(1) << win) : '0;
  assign probe_ready_o = !fill_valid_i;
  assign bank_idx = {set[SET_BITS-1:BANK_W], way_sel};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_we[b] = (src == SRC_FILL) && (bank == BANK_W'(b));
    assign bank_re[b] = core_acc && hit && (bank == BANK_W'(b));
    data_bank #(.DEPTH(BANK_DEPTH), .DATA_W(DATA_W)) u_bank (
      .clk_i, .rst_ni, .we_i(bank_we[b]), .re_i(bank_re[b]), .addr_i(bank_idx),
      .wdata_i(fill_data_i), .rdata_o(bank_rdata[b])
    );
    AST_BANK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bank_re[b] |=> !bank_re[b]); // R6
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        vld_q[s]  <= '0;
        tree_q[s] <= '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
          tag_q[s][w]  <= '0;
          pres_q[s][w] <= '0;
        end
      end
      busy_q <= '0;
      rsp_valid_o <= 1'b0; rsp_hit_o <= 1'b0; rsp_core_o <= '0; rsp_bank_q <= '0;
      fill_req_o <= 1'b0; fill_req_addr_o <= '0; fill_req_core_o <= '0;
      probe_rsp_valid_o <= 1'b0; probe_hit_o <= 1'b0; probe_fwd_o <= '0;
      binv_valid_o <= 1'b0; binv_addr_o <= '0; binv_mask_o <= '0;
    end else begin
      busy_q <= bank_we | bank_re;
      rsp_valid_o <= core_acc;
      rsp_hit_o   <= core_acc && hit;
      rsp_core_o  <= win;
      rsp_bank_q  <= bank;
      fill_req_o  <= core_acc && !hit;
      fill_req_addr_o <= lk_addr;
      fill_req_core_o <= win;
      probe_rsp_valid_o <= (src == SRC_PROBE);
      probe_hit_o <= (src == SRC_PROBE) && hit;
      probe_fwd_o <= ((src == SRC_PROBE) && hit) ? pres_q[set][hit_way] : '0;
      binv_valid_o <= (src == SRC_FILL) && vld_q[set][victim] && (pres_q[set][victim] != '0);
      binv_addr_o  <= {tag_q[set][victim], set};
      binv_mask_o  <= pres_q[set][victim];
      if (tree_upd) tree_q[set] <= tree_nxt;
      if (src == SRC_FILL) begin
        vld_q[set][victim]  <= 1'b1;
        tag_q[set][victim]  <= tag;
        pres_q[set][victim] <= NUM_CORES'(1) << fill_core_i;
      end else if (core_acc && hit) begin
        pres_q[set][hit_way] <= pres_q[set][hit_way] | (NUM_CORES'(1) << win);
      end
    end
  end

  assign rsp_data_o = rsp_hit_o ? bank_rdata[rsp_bank_q] : '0;

  AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(core_gnt_o)); // R2
  AST_PROBE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (probe_valid_i || fill_valid_i) |-> core_gnt_o == '0); // R3
  AST_MISS_FROM_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_o |-> $past(core_gnt_o != '0)); // R5
  AST_PROBE_FILTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (probe_rsp_valid_o && !probe_hit_o) |-> probe_fwd_o == '0); // R7
  AST_BINV_AFTER_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    binv_valid_o |-> ($past(fill_valid_i) && binv_mask_o != '0)); // R10
endmodule

// File: tb/test_shared_tag_ctrl.sv
`timescale 1ns/1ps
module test_shared_tag_ctrl;
  localparam int TB = 6, SB = 3, LW = TB + SB, DW = 8;

  logic clk = 0, rst_ni = 0;
  logic [3:0] core_req = 0, core_gnt;
  logic [4*LW-1:0] core_addr = 0;
  logic rsp_valid, rsp_hit, fill_req, probe_ready, probe_rsp_valid, probe_hit, binv_valid;
  logic [1:0] rsp_core, fill_req_core, fill_core = 0;
  logic [DW-1:0] rsp_data, fill_data = 0;
  logic [LW-1:0] fill_req_addr, fill_addr = 0, probe_addr = 0, binv_addr;
  logic fill_valid = 0, probe_valid = 0;
  logic [3:0] probe_fwd, binv_mask;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  shared_tag_ctrl #(.NUM_CORES(4), .NUM_WAYS(16), .NUM_BANKS(4), .SET_BITS(SB),
    .TAG_BITS(TB), .DATA_W(DW)) i_shared_tag_ctrl (
    .clk_i(clk), .rst_ni, .core_req_i(core_req), .core_addr_i(core_addr),
    .core_gnt_o(core_gnt), .rsp_valid_o(rsp_valid), .rsp_core_o(rsp_core),
    .rsp_hit_o(rsp_hit), .rsp_data_o(rsp_data), .fill_req_o(fill_req),
    .fill_req_addr_o(fill_req_addr), .fill_req_core_o(fill_req_core),
    .fill_valid_i(fill_valid), .fill_addr_i(fill_addr), .fill_core_i(fill_core),
    .fill_data_i(fill_data), .probe_valid_i(probe_valid), .probe_addr_i(probe_addr),
    .probe_ready_o(probe_ready), .probe_rsp_valid_o(probe_rsp_valid),
    .probe_hit_o(probe_hit), .probe_fwd_o(probe_fwd), .binv_valid_o(binv_valid),
    .binv_addr_o(binv_addr), .binv_mask_o(binv_mask));

  function automatic logic [LW-1:0] la(int t, int s);
    return {TB'(t), SB'(s)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns at a negedge after the response edge
  task automatic lookup(input int c, input int t, input int s, output int stalls);
    stalls = 0;
    core_addr[c*LW +: LW] = la(t, s);
    core_req[c] = 1;
    #1;
    while (!core_gnt[c] && stalls < 8) begin
      @(negedge clk); #1; stalls++;
    end
    @(negedge clk);
    core_req[c] = 0;
  endtask

  task automatic do_fill(input int t, input int s, input int c, input int d);
    fill_addr = la(t, s); fill_core = 2'(c); fill_data = DW'(d); fill_valid = 1;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic do_probe(input int t, input int s);
    probe_addr = la(t, s); probe_valid = 1;
    @(negedge clk);
    probe_valid = 0;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int st, g, prev;
    logic [3:0] seen;
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !fill_req && !probe_rsp_valid && !binv_valid, "R1 outputs idle", 1, 0);
    rst_ni = 1;
    @(negedge clk);
    // R1/R5: first lookup misses
    lookup(0, 1, 0, st);
    chk(rsp_valid && !rsp_hit && rsp_data == 0, "R5 miss rsp", int'(rsp_hit), 0);
    chk(fill_req && fill_req_addr == la(1, 0) && fill_req_core == 0, "R5 fill req",
        int'(fill_req_addr), int'(la(1, 0)));
    // R9: fill 16 ways, invalid-first, no eviction
    for (int t = 1; t <= 16; t++) begin
      do_fill(t, 0, t % 4, t * 3);
      chk(!binv_valid, "R9 no evict while invalid", int'(binv_valid), 0);
    end
    @(negedge clk);
    // R4/R6/R8: hit sweep in way order, all on bank 0
    for (int t = 1; t <= 16; t++) begin
      lookup((t + 1) % 4, t, 0, st);
      chk(rsp_valid && rsp_hit && int'(rsp_data) == t * 3 && int'(rsp_core) == (t + 1) % 4,
          "R4 hit data", int'(rsp_data), t * 3);
      chk(st == (t == 1 ? 0 : 1), "R6 bank stall", st, t == 1 ? 0 : 1);
    end
    // R6: miss right after a hit on the same bank is not stalled
    lookup(1, 50, 0, st);
    chk(st == 0 && !rsp_hit, "R6 miss no stall", st, 0);
    // R8: probe hits forward presence
    for (int t = 1; t <= 16; t++) begin
      do_probe(t, 0);
      chk(probe_rsp_valid && probe_hit && probe_fwd == ((4'd1 << (t % 4)) | (4'd1 << ((t + 1) % 4))),
          "R8 probe fwd", int'(probe_fwd), int'((4'd1 << (t % 4)) | (4'd1 << ((t + 1) % 4))));
    end
    // R7: probe misses absorbed
    do_probe(40, 0);
    chk(probe_rsp_valid && !probe_hit && probe_fwd == 0, "R7 probe miss", int'(probe_fwd), 0);
    do_probe(1, 1);
    chk(!probe_hit && probe_fwd == 0, "R7 probe other set", int'(probe_hit), 0);
    // R3: probe beats core
    core_addr[0 +: LW] = la(33, 1); core_req[0] = 1;
    probe_addr = la(2, 0); probe_valid = 1;
    #1;
    chk(core_gnt == 0 && probe_ready, "R3 probe first", int'(core_gnt), 0);
    @(negedge clk);
    probe_valid = 0;
    chk(probe_rsp_valid && probe_hit, "R3 probe rsp", int'(probe_rsp_valid), 1);
    #1;
    chk(core_gnt == 4'b0001, "R3 core after probe", int'(core_gnt), 1);
    @(negedge clk);
    core_req[0] = 0;
    // R3: fill beats core and probe
    core_req[0] = 1; fill_addr = la(40, 2); fill_core = 0; fill_data = 1; fill_valid = 1;
    #1;
    chk(core_gnt == 0 && !probe_ready, "R3 fill first", int'(core_gnt), 0);
    @(negedge clk);
    fill_valid = 0; core_req[0] = 0;
    @(negedge clk);
    // R2: four cores, cyclic order
    for (int c = 0; c < 4; c++) core_addr[c*LW +: LW] = la(30 + c, 1);
    core_req = 4'hf; seen = 0; prev = -1;
    for (int k = 0; k < 4; k++) begin
      #1;
      g = -1;
      for (int c = 0; c < 4; c++) if (core_gnt[c]) g = c;
      chk(g >= 0 && $onehot(core_gnt), "R2 one grant", int'(core_gnt), 1);
      if (prev >= 0) chk(g == (prev + 1) % 4, "R2 cyclic order", g, (prev + 1) % 4);
      if (g >= 0) begin seen[g] = 1; prev = g; end
      @(negedge clk);
      if (g >= 0) core_req[g] = 0;
    end
    core_req = 0;
    chk(seen == 4'hf, "R2 all served", int'(seen), 15);
    @(negedge clk);
    // R9/R10: full set, victim way 0 (tag 1)
    do_fill(20, 0, 3, 8'h55);
    chk(binv_valid && binv_addr == la(1, 0) && binv_mask == 4'b0110, "R10 binv first",
        int'(binv_addr), int'(la(1, 0)));
    lookup(0, 1, 0, st);
    chk(!rsp_hit, "R9 evicted line misses", int'(rsp_hit), 0);
    lookup(3, 20, 0, st);
    chk(rsp_hit && rsp_data == 8'h55, "R4 new line data", int'(rsp_data), 8'h55);
    do_probe(20, 0);
    chk(probe_fwd == 4'b1000, "R8 fill presence", int'(probe_fwd), 8);
    // next victim by tree is way 8 (tag 9)
    do_fill(21, 0, 0, 8'h66);
    chk(binv_valid && binv_addr == la(9, 0) && binv_mask == 4'b0110, "R9 tree victim",
        int'(binv_addr), int'(la(9, 0)));
    lookup(1, 9, 0, st);
    chk(!rsp_hit, "R9 second victim misses", int'(rsp_hit), 0);
    @(negedge clk);
    chk(!binv_valid && !rsp_valid, "R10 pulse ends", int'(binv_valid), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule